// File: doc/BRIEF.md
# Sequence-Tagged Fetch Redirect Unit

This unit sits at the front of an in-order pipeline. It issues one cache-line fetch request per accepted handshake and stamps each request with four tags: a thread id (always zero), the stream number it currently expects, the prediction number it last adopted, and a local line counter used only to tell lines apart when debugging. Returned lines come back through the line return input. The unit forwards a returned line, one cycle later and with its tags unchanged, only if the line's stream number matches the stream that is expected.

Two agents can move the fetch address. The back end sends an execute redirect with a new PC and a new stream number after a branch or an exception. Every line of the old stream still in flight then becomes stale, and the unit drops it when it returns. No queue is flushed. A later line-decode stage can send a predicted redirect with a new PC and a new prediction number. The unit accepts it only if the stream number it carries is the one currently expected. The consumer downstream discards lines whose prediction number is out of date. Redirect addresses are aligned down to a line boundary. In a cycle that takes a redirect, no request is issued.

Top module: `seqtag_fetch_gen`

## Requirements
- R1: While reset is held, req_valid and out_valid are 0. After reset, the first request has address RESET_PC (default 0x100), stream 1, prediction 1, line number 1 and thread 0.
- R2: Each request taken with req_ready high advances the address by LINE_BYTES (default 16) and the line number by 1 in the next cycle. Without a handshake, address and line number hold.
- R3: An execute redirect forces req_valid low in its own cycle. In the next cycle the request carries the new stream, the redirect PC with its low 4 bits cleared, the unchanged prediction number, and the unchanged line number.
- R4: A predict redirect whose stream equals the current req_stream forces req_valid low in its own cycle. In the next cycle the request carries its prediction number and its line-aligned PC.
- R5: A predict redirect whose stream differs from the current req_stream is ignored. The request proceeds as if no redirect had been sent.
- R6: When both redirects arrive in the same cycle, only the execute redirect takes effect. The prediction number stays unchanged even if the predict redirect's stream matches.
- R7: A returned line whose stream equals the expected stream, counted after any execute redirect in that same cycle, appears on the output one cycle later. Its address, data, stream, prediction and line number are unchanged, and out_thread is 0.
- R8: A returned line whose stream differs from that expected stream produces no output (out_valid stays 0 in the next cycle).
- R9: All sequence numbers are 16 bits and compared only for equality. The line number wraps from 0xFFFF to 0, and a stream of 0xFFFF is handled like any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_redir_valid | input | 1 | Execute redirect strobe |
| ex_redir_pc | input | PC_W | Execute redirect target |
| ex_redir_stream | input | SEQ_W | New stream number from execute |
| pr_redir_valid | input | 1 | Predict redirect strobe |
| pr_redir_pc | input | PC_W | Predicted target |
| pr_redir_stream | input | SEQ_W | Stream the prediction belongs to |
| pr_redir_pred | input | SEQ_W | New prediction number |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Line request accepted |
| req_addr | output | PC_W | Line-aligned fetch address |
| req_stream | output | SEQ_W | Stream tag (current expected stream) |
| req_pred | output | SEQ_W | Prediction tag |
| req_line_seq | output | SEQ_W | Debug line number |
| ret_valid | input | 1 | Returned line valid |
| ret_addr | input | PC_W | Returned line address |
| ret_data | input | DATA_W | Returned line data |
| ret_stream | input | SEQ_W | Returned stream tag |
| ret_pred | input | SEQ_W | Returned prediction tag |
| ret_line_seq | input | SEQ_W | Returned line number |
| out_valid | output | 1 | Tagged line valid |
| out_addr | output | PC_W | Tagged line address |
| out_data | output | DATA_W | Tagged line data |
| out_thread | output | TID_W | Thread id, always 0 |
| out_stream | output | SEQ_W | Stream tag |
| out_pred | output | SEQ_W | Prediction tag |
| out_line_seq | output | SEQ_W | Line number |

## Verification
Two things can happen in the same cycle: a line returns while an execute redirect changes the expected stream, and a predict redirect competes with an execute redirect. The bench sweeps every combination of both redirect strobes, predict-stream match, req_ready, return valid, and return stream. The return stream is picked as the new stream, the old stream, or an unrelated value. A running model of the expected stream, prediction number, address and line number decides what the outcome should be. Under that model, a line carrying the old stream must be dropped. A matching prediction that loses to an execute redirect must leave req_pred unchanged.

// File: rtl/seqtag_fetch_gen.sv
module seqtag_fetch_gen #(
  parameter int PC_W = 32,
  parameter int SEQ_W = 16,
  parameter int DATA_W = 64,
  parameter int TID_W = 2,
  parameter int LINE_BYTES = 16,
  parameter logic [PC_W-1:0] RESET_PC = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_redir_valid,
  input  logic [PC_W-1:0]   ex_redir_pc,
  input  logic [SEQ_W-1:0]  ex_redir_stream,
  input  logic              pr_redir_valid,
  input  logic [PC_W-1:0]   pr_redir_pc,
  input  logic [SEQ_W-1:0]  pr_redir_stream,
  input  logic [SEQ_W-1:0]  pr_redir_pred,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [PC_W-1:0]   req_addr,
  output logic [SEQ_W-1:0]  req_stream,
  output logic [SEQ_W-1:0]  req_pred,
  output logic [SEQ_W-1:0]  req_line_seq,
  input  logic              ret_valid,
  input  logic [PC_W-1:0]   ret_addr,
  input  logic [DATA_W-1:0] ret_data,
  input  logic [SEQ_W-1:0]  ret_stream,
  input  logic [SEQ_W-1:0]  ret_pred,
  input  logic [SEQ_W-1:0]  ret_line_seq,
  output logic              out_valid,
  output logic [PC_W-1:0]   out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [TID_W-1:0]  out_thread,
  output logic [SEQ_W-1:0]  out_stream,
  output logic [SEQ_W-1:0]  out_pred,
  output logic [SEQ_W-1:0]  out_line_seq
);
  localparam logic [PC_W-1:0] ALIGN_MASK = ~(PC_W'(LINE_BYTES - 1));
  localparam logic [PC_W-1:0] LINE_STEP  = PC_W'(LINE_BYTES);
  localparam logic [SEQ_W-1:0] SEQ_INIT  = SEQ_W'(1);

  logic             run;
  logic [SEQ_W-1:0] exp_stream, cur_pred, line_seq;
  logic [PC_W-1:0]  fetch_pc;

  wire pr_take  = pr_redir_valid && !ex_redir_valid && (pr_redir_stream == exp_stream);
  wire redirect = ex_redir_valid || pr_take;
  wire issue    = req_valid && req_ready;
  wire [SEQ_W-1:0] stream_nx = ex_redir_valid ? ex_redir_stream : exp_stream;
  wire keep_line = ret_valid && (ret_stream == stream_nx);

  assign req_valid    = run && !redirect;
  assign req_addr     = fetch_pc;
  assign req_stream   = exp_stream;
  assign req_pred     = cur_pred;
  assign req_line_seq = line_seq;
  assign out_thread   = '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      exp_stream <= SEQ_INIT;
      cur_pred   <= SEQ_INIT;
      line_seq   <= SEQ_INIT;
      fetch_pc   <= RESET_PC & ALIGN_MASK;
    end else begin
      run <= 1'b1;
      if (ex_redir_valid) begin
        exp_stream <= ex_redir_stream;
        fetch_pc   <= ex_redir_pc & ALIGN_MASK;
      end else if (pr_take) begin
        cur_pred <= pr_redir_pred;
        fetch_pc <= pr_redir_pc & ALIGN_MASK;
      end else if (issue) begin
        fetch_pc <= fetch_pc + LINE_STEP;
        line_seq <= line_seq + SEQ_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_addr     <= '0;
      out_data     <= '0;
      out_stream   <= '0;
      out_pred     <= '0;
      out_line_seq <= '0;
    end else begin
      out_valid <= keep_line;
      if (keep_line) begin
        out_addr     <= ret_addr;
        out_data     <= ret_data;
        out_stream   <= ret_stream;
        out_pred     <= ret_pred;
        out_line_seq <= ret_line_seq;
      end
    end
  end
endmodule

module seqtag_fetch_gen_chk #(
  parameter int PC_W = 32,
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ex_redir_valid,
  input logic [SEQ_W-1:0] ex_redir_stream,
  input logic             pr_redir_valid,
  input logic [SEQ_W-1:0] pr_redir_stream,
  input logic             req_valid,
  input logic             req_ready,
  input logic [PC_W-1:0]  req_addr,
  input logic [SEQ_W-1:0] req_stream,
  input logic [SEQ_W-1:0] req_pred,
  input logic [SEQ_W-1:0] req_line_seq,
  input logic             out_valid,
  input logic [SEQ_W-1:0] out_stream
);
  assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> req_line_seq == $past(req_line_seq) + SEQ_W'(1));

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !pr_redir_valid |=> $stable(req_addr) && $stable(req_line_seq));

  assert_ex_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redir_valid |=> req_stream == $past(ex_redir_stream));

  assert_pred_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pr_redir_valid && !ex_redir_valid && pr_redir_stream != req_stream |=> $stable(req_pred));

  assert_ex_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_redir_valid |=> $stable(req_pred));

  assert_out_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_stream == req_stream);
endmodule

bind seqtag_fetch_gen seqtag_fetch_gen_chk #(.PC_W(PC_W), .SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ex_redir_valid(ex_redir_valid), .ex_redir_stream(ex_redir_stream),
  .pr_redir_valid(pr_redir_valid), .pr_redir_stream(pr_redir_stream),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .req_stream(req_stream), .req_pred(req_pred), .req_line_seq(req_line_seq),
  .out_valid(out_valid), .out_stream(out_stream)
);

// File: tb/tb_seqtag_fetch_gen.sv
module tb_seqtag_fetch_gen;
  localparam int PERIOD = 10;
  localparam int PC_W = 32, SEQ_W = 16, DATA_W = 64, TID_W = 2;

  logic clk = 0, rst_n = 0;
  logic ex_redir_valid = 0, pr_redir_valid = 0, req_ready = 0, ret_valid = 0;
  logic [PC_W-1:0] ex_redir_pc = 0, pr_redir_pc = 0, ret_addr = 0;
  logic [SEQ_W-1:0] ex_redir_stream = 0, pr_redir_stream = 0, pr_redir_pred = 0;
  logic [SEQ_W-1:0] ret_stream = 0, ret_pred = 0, ret_line_seq = 0;
  logic [DATA_W-1:0] ret_data = 0;
  logic req_valid, out_valid;
  logic [PC_W-1:0] req_addr, out_addr;
  logic [SEQ_W-1:0] req_stream, req_pred, req_line_seq, out_stream, out_pred, out_line_seq;
  logic [DATA_W-1:0] out_data;
  logic [TID_W-1:0] out_thread;

  seqtag_fetch_gen dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [PC_W-1:0] m_addr = 'h100;
  logic [SEQ_W-1:0] m_stream = 1, m_pred = 1, m_seq = 1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit exv, input logic [PC_W-1:0] expc, input logic [SEQ_W-1:0] exs,
                     input bit prv, input logic [PC_W-1:0] prpc, input logic [SEQ_W-1:0] prs,
                     input logic [SEQ_W-1:0] prp, input bit rdy,
                     input bit rv, input logic [SEQ_W-1:0] rs, input logic [63:0] rd);
    bit take_pr, exp_out;
    ex_redir_valid = exv; ex_redir_pc = expc; ex_redir_stream = exs;
    pr_redir_valid = prv; pr_redir_pc = prpc; pr_redir_stream = prs; pr_redir_pred = prp;
    req_ready = rdy;
    ret_valid = rv; ret_stream = rs; ret_data = rd; ret_addr = PC_W'(rd) & ~32'hF;
    ret_pred = SEQ_W'(rd >> 8); ret_line_seq = SEQ_W'(rd >> 24);
    #1;
    take_pr = prv && !exv && (prs == m_stream);
    chk(exv ? "R3" : (take_pr ? "R4" : "R2"), 64'(req_valid), 64'(!(exv || take_pr)));
    chk("R2", 64'(req_addr), 64'(m_addr));
    chk("R3", 64'(req_stream), 64'(m_stream));
    chk("R6", 64'(req_pred), 64'(m_pred));
    chk("R9", 64'(req_line_seq), 64'(m_seq));
    if (exv) begin m_stream = exs; m_addr = expc & ~32'hF; end
    else if (take_pr) begin m_pred = prp; m_addr = prpc & ~32'hF; end
    else if (rdy) begin m_addr = m_addr + 16; m_seq = m_seq + 1; end
    exp_out = rv && (rs == m_stream);
    @(posedge clk); @(negedge clk);
    chk(exp_out ? "R7" : "R8", 64'(out_valid), 64'(exp_out));
    if (exp_out) begin
      chk("R7", out_data, rd);
      chk("R7", 64'(out_addr), 64'(PC_W'(rd) & ~32'hF));
      chk("R7", 64'(out_stream), 64'(rs));
      chk("R7", 64'(out_pred), 64'(SEQ_W'(rd >> 8)));
      chk("R7", 64'(out_line_seq), 64'(SEQ_W'(rd >> 24)));
      chk("R7", 64'(out_thread), 64'd0);
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", 64'(req_valid), 64'd0);
    chk("R1", 64'(out_valid), 64'd0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1", 64'(req_valid), 64'd1);
    chk("R1", 64'(req_addr), 64'h100);
    chk("R1", 64'(req_stream), 64'd1);
    chk("R1", 64'(req_pred), 64'd1);
    chk("R1", 64'(req_line_seq), 64'd1);
    for (int k = 0; k < 1024; k++) begin
      logic [SEQ_W-1:0] nstr, exs, prs, rs;
      exs  = m_stream + SEQ_W'(3 + k);
      prs  = k[2] ? m_stream : m_stream + SEQ_W'(1);
      nstr = k[0] ? exs : m_stream;
      case (k[6:5])
        2'd0: rs = nstr;
        2'd1: rs = m_stream;
        2'd2: rs = nstr + SEQ_W'(9);
        default: rs = nstr;
      endcase
      cyc(k[0], 32'h4000 + 32'(k * 37), exs,
          k[1], 32'h8000 + 32'(k * 53), prs, SEQ_W'(k * 7 + 2), k[3],
          k[4], rs, {16'(k), 16'(k ^ 16'h5a5a), 16'(k * 3), 16'(k + 1)} ^ 64'(k[9:7]));
    end
    cyc(1, 32'h2000, 16'hFFFF, 0, 0, 0, 0, 1, 1, 16'hFFFF, 64'h11);
    cyc(0, 0, 0, 1, 32'h3008, 16'hFFFF, 16'h0077, 1, 1, 16'hFFFF, 64'h22);
    cyc(1, 32'h5000, 16'h0000, 1, 32'h6000, 16'hFFFF, 16'h0099, 1, 1, 16'hFFFF, 64'h33);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 16'h0000, 64'h44);
    for (int i = 0; i < 65540; i++)
      cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule